// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

A register-mapped timer peripheral for a plain 32-bit read/write bus. Software writes a start value into a pair of load words, picks one-shot or auto-reload behaviour and a 32-bit or 64-bit count width, then sets the run bit. The counter takes the load value when the run bit goes from 0 to 1 and then steps down by one on every clock. When the count is zero on a running clock edge, the timer expires. A periodic timer reloads and keeps going. A one-shot timer stops at zero and drops its run bit.

Each expiry sets a sticky pending flag. The flag stays set until software writes a one to a clear bit. The interrupt word shows the pending flag both before and after masking by an enable bit. The `irq` output is a level that follows the masked view. The live count can be read through two word pairs that return the same value, the direct pair and the shadow pair.

Bus access takes one cycle. A write takes effect on the clock edge where `wr_en` is high. Read data appears on `rdata` the cycle after `rd_en`, and it shows the state at the strobe edge. Byte offsets: 0x00 load low, 0x04 load high, 0x08 count low, 0x0C count high, 0x10 control, 0x14 interrupt, 0x18 shadow count low, 0x1C shadow count high.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, every mapped word reads 0, the timer is stopped and `irq` is 0.
- R2: The load words read back as written. Control stores only bit 0 (1 = periodic, 0 = one-shot), bit 1 (run) and bit 16 (1 = 64-bit width); all other control bits read 0. Interrupt bits 31..4 and bit 3 read 0.
- R3: A control write that takes the run bit from 0 to 1 copies the load value into the counter on that edge. In 32-bit width the high load word is ignored.
- R4: While running, the count drops by one per clock. If the load value is L and run is set at edge E, the first expiry occurs at edge E+L+1.
- R5: In periodic mode the counter reloads on expiry and keeps running, so expiries repeat every L+1 clocks.
- R6: In one-shot mode the counter stays at 0 after expiry, and the run bit reads 0 from the next cycle on.
- R7: In 32-bit width the high count word reads 0. In 64-bit width a borrow out of the low word decrements the high word.
- R8: Interrupt bit 1 (raw) is set on every expiry and stays set until a write with bit 3 = 1 to the interrupt word. A write with bit 3 = 0 leaves it unchanged.
- R9: Interrupt bit 2 reads raw AND enable (bit 0), and `irq` equals that same value. `irq` is registered and rises on the expiry edge.
- R10: If an expiry and a clear write fall on the same edge, raw ends up set.
- R11: The count words and the shadow count words return the same live count. `rdata` holds the value from the `rd_en` edge one cycle later and is 0 when no read is strobed.
- R12: Reads from an offset that is unmapped or not word-aligned return 0. Writes to such offsets, and to the four count words, change nothing.
- R13: Clearing the run bit freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, data returned next cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request, raw AND enable |

## Verification
For each load value from 0 to 5, the bench runs the timer in periodic mode with the interrupt enabled and in one-shot mode with it masked. It reads the count on every clock, alternating between the direct and shadow words. These sweeps separate reload from halting, check the L+1 expiry edge against an off-by-one, and check that the mask changes `irq` but not the raw flag. A 64-bit run with a high load word of 1 steps through the low-word wrap, which shows whether the borrow reaches the high word. A 32-bit run with a nonzero high load word shows that the high half is dropped. A clear write timed onto the expiry edge shows whether set or clear wins.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // word index = byte offset >> 2
  localparam logic [2:0] IDX_LOAD_LO = 3'd0;
  localparam logic [2:0] IDX_LOAD_HI = 3'd1;
  localparam logic [2:0] IDX_CNT_LO  = 3'd2;
  localparam logic [2:0] IDX_CNT_HI  = 3'd3;
  localparam logic [2:0] IDX_CTRL    = 3'd4;
  localparam logic [2:0] IDX_INT     = 3'd5;
  localparam logic [2:0] IDX_SHD_LO  = 3'd6;
  localparam logic [2:0] IDX_SHD_HI  = 3'd7;
  localparam int NUM_WORDS = 8;

  localparam int CTRL_PERIODIC_BIT = 0;
  localparam int CTRL_RUN_BIT      = 1;
  localparam int CTRL_WIDE_BIT     = 16;

  localparam int INT_EN_BIT  = 0;
  localparam int INT_RAW_BIT = 1;
  localparam int INT_MSK_BIT = 2;
  localparam int INT_CLR_BIT = 3;
endpackage

// File: rtl/evt_timer_counter.sv
module evt_timer_counter #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic              wide,
  input  logic              periodic,
  input  logic [2*HALF_W-1:0] load,
  output logic [2*HALF_W-1:0] cnt,
  output logic              expire
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] lo_dec;
  logic zero;

  assign zero   = wide ? (cnt_q == '0) : (cnt_q[HALF_W-1:0] == '0);
  assign expire = run & zero;
  assign lo_dec = cnt_q[HALF_W-1:0] - 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = load;
    end else if (run) begin
      if (zero) begin
        if (periodic) cnt_d = load;
      end else if (wide) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d[HALF_W-1:0] = lo_dec;
      end
    end
    if (!wide) cnt_d[CNT_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic en_we,
  input  logic en_wd,
  output logic en_q,
  output logic raw_q,
  output logic irq_q
);
  logic raw_d, en_d;

  // a set on the same edge as a clear wins
  assign raw_d = set ? 1'b1 : (clr ? 1'b0 : raw_q);
  assign en_d  = en_we ? en_wd : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
      irq_q <= raw_d & en_d;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic              in_map;
  logic [2:0]        idx;
  logic [NUM_WORDS-1:0] wr_sel;

  logic [DATA_W-1:0] load_lo_q, load_hi_q;
  logic              periodic_q, run_q, wide_q;
  logic              wide_eff, start, halt;
  logic [CNT_W-1:0]  cnt;
  logic              expire;
  logic              int_en, int_raw;
  logic [DATA_W-1:0] rd_word, rdata_q;

  assign idx    = addr[4:2];
  assign in_map = (addr[1:0] == 2'b00) && ((addr >> 5) == '0);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wsel
    assign wr_sel[w] = wr_en && in_map && (idx == w[2:0]);
  end

  assign start    = wr_sel[IDX_CTRL] & wdata[CTRL_RUN_BIT] & ~run_q;
  assign wide_eff = wr_sel[IDX_CTRL] ? wdata[CTRL_WIDE_BIT] : wide_q;
  assign halt     = expire & ~periodic_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_lo_q  <= '0;
      load_hi_q  <= '0;
      periodic_q <= 1'b0;
      run_q      <= 1'b0;
      wide_q     <= 1'b0;
    end else begin
      if (wr_sel[IDX_LOAD_LO]) load_lo_q <= wdata;
      if (wr_sel[IDX_LOAD_HI]) load_hi_q <= wdata;
      if (wr_sel[IDX_CTRL]) begin
        periodic_q <= wdata[CTRL_PERIODIC_BIT];
        run_q      <= wdata[CTRL_RUN_BIT];
        wide_q     <= wdata[CTRL_WIDE_BIT];
      end else if (halt) begin
        run_q <= 1'b0;
      end
    end
  end

  evt_timer_counter #(.HALF_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .run      (run_q),
    .wide     (wide_eff),
    .periodic (periodic_q),
    .load     ({load_hi_q, load_lo_q}),
    .cnt      (cnt),
    .expire   (expire)
  );

  evt_timer_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .set   (expire),
    .clr   (wr_sel[IDX_INT] & wdata[INT_CLR_BIT]),
    .en_we (wr_sel[IDX_INT]),
    .en_wd (wdata[INT_EN_BIT]),
    .en_q  (int_en),
    .raw_q (int_raw),
    .irq_q (irq)
  );

  always_comb begin
    rd_word = '0;
    if (in_map) begin
      case (idx)
        IDX_LOAD_LO: rd_word = load_lo_q;
        IDX_LOAD_HI: rd_word = load_hi_q;
        IDX_CNT_LO, IDX_SHD_LO: rd_word = cnt[DATA_W-1:0];
        IDX_CNT_HI, IDX_SHD_HI: rd_word = cnt[CNT_W-1:DATA_W];
        IDX_CTRL: begin
          rd_word[CTRL_PERIODIC_BIT] = periodic_q;
          rd_word[CTRL_RUN_BIT]      = run_q;
          rd_word[CTRL_WIDE_BIT]     = wide_q;
        end
        IDX_INT: begin
          rd_word[INT_EN_BIT]  = int_en;
          rd_word[INT_RAW_BIT] = int_raw;
          rd_word[INT_MSK_BIT] = int_en & int_raw;
        end
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_en ? rd_word : '0;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              in_map,
  input logic              run_q,
  input logic              periodic_q,
  input logic              wide_q,
  input logic              start,
  input logic              expire,
  input logic              int_en,
  input logic              int_raw,
  input logic [2*DATA_W-1:0] cnt
);
  logic clr_wr, ctrl_wr;
  assign clr_wr  = wr_en && addr == ADDR_W'(8'h14) && wdata[3];
  assign ctrl_wr = wr_en && addr == ADDR_W'(8'h10);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!irq && !run_q && !int_raw));

  p_expire_sets_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> int_raw);

  p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !expire) |=> !int_raw);

  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && expire) |=> int_raw);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (int_raw && int_en));

  p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic_q && !ctrl_wr) |=> !run_q);

  p_narrow_high_r7: assert property (@(posedge clk) disable iff (rst)
    !wide_q |-> cnt[2*DATA_W-1:DATA_W] == '0);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_map) |=> rdata == '0);

  p_freeze_r13: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start) |=> $stable(cnt));
endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .irq        (irq),
  .in_map     (in_map),
  .run_q      (run_q),
  .periodic_q (periodic_q),
  .wide_q     (wide_q),
  .start      (start),
  .expire     (expire),
  .int_en     (int_en),
  .int_raw    (int_raw),
  .cnt        (cnt)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [7:0] A_LLO = 8'h00, A_LHI = 8'h04, A_VLO = 8'h08, A_VHI = 8'h0C;
  localparam logic [7:0] A_CTL = 8'h10, A_INT = 8'h14, A_SLO = 8'h18, A_SHI = 8'h1C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every word
    for (int w = 0; w < 8; w++) begin
      rd(8'(w * 4), v);
      check("R1 reset word", v, 0);
    end
    check("R1 irq after reset", irq, 0);

    // R2: readback and field masking
    wr(A_LLO, 32'hA5A5_1234); rd(A_LLO, v); check("R2 load low", v, 32'hA5A5_1234);
    wr(A_LHI, 32'h0000_00C3); rd(A_LHI, v); check("R2 load high", v, 32'h0000_00C3);
    wr(A_CTL, 32'hFFFF_FFFD); rd(A_CTL, v); check("R2 ctrl mask", v, 32'h0001_0001);
    wr(A_CTL, 32'h0);
    wr(A_INT, 32'hFFFF_FFF1); rd(A_INT, v); check("R2 int mask", v, 32'h1);
    wr(A_INT, 32'h0);

    // R12: unmapped, misaligned, read-only count words
    wr(A_LLO, 32'h0000_0077);
    wr(8'h20, 32'hDEAD_BEEF); rd(8'h20, v); check("R12 unmapped read", v, 0);
    wr(8'h01, 32'hDEAD_BEEF); rd(A_LLO, v); check("R12 misaligned write ignored", v, 32'h77);
    rd(8'h02, v); check("R12 misaligned read", v, 0);
    wr(A_VLO, 32'h1234); rd(A_VLO, v); check("R12 count word read-only", v, 0);
    wr(A_SHI, 32'h1234); rd(A_SHI, v); check("R12 shadow word read-only", v, 0);
    check("R11 rdata idle is zero", rdata, 0);

    // R4 R5 R6 R9 R11: sweep of load values in both modes
    for (int m = 0; m < 2; m++) begin
      for (int L = 0; L <= 5; L++) begin
        int inten;
        inten = m;  // periodic runs unmasked, one-shot runs masked
        wr(A_CTL, 32'h0);
        wr(A_INT, 32'h8 | 32'(inten));
        wr(A_LLO, 32'(L));
        wr(A_LHI, 32'h0);
        wr(A_CTL, 32'h2 | 32'(m));  // run edge E0
        for (int i = 0; i < 12; i++) begin
          int e;
          rd((i % 2 == 0) ? A_VLO : A_SLO, v);
          if (m == 1) e = L - (i % (L + 1));
          else        e = (i <= L) ? L - i : 0;
          check(m ? "R5 periodic count" : "R6 one-shot count", v, 64'(e));
          check("R9 irq level", irq, (inten != 0 && i + 1 >= L + 1) ? 1 : 0);
        end
        rd(A_INT, v);
        check("R9 int status view", v, inten ? 32'h7 : 32'h2);
        rd(A_CTL, v);
        check(m ? "R5 still running" : "R6 run bit dropped", v, m ? 32'h3 : 32'h0);
      end
    end

    // R8: write without clear bit keeps raw, write with it drops raw
    wr(A_CTL, 32'h0);
    rd(A_INT, v); check("R8 raw pending", v, 32'h7);
    wr(A_INT, 32'h1); rd(A_INT, v); check("R8 bit3=0 keeps raw", v, 32'h7);
    wr(A_INT, 32'h9); rd(A_INT, v); check("R8 clear drops raw", v, 32'h1);
    check("R9 irq drops after clear", irq, 0);

    // R10: clear lands on the expiry edge (L=3, expiry at E0+4)
    wr(A_LLO, 32'd3);
    wr(A_CTL, 32'h2);     // E0
    idle(3);              // edges E0+1..E0+3
    wr(A_INT, 32'h9);     // edge E0+4
    rd(A_INT, v); check("R10 set beats clear", v, 32'h7);
    check("R10 irq stays high", irq, 1);
    wr(A_INT, 32'h9); rd(A_INT, v); check("R10 later clear works", v, 32'h1);

    // R3 R7: 64-bit width with borrow into the high word
    wr(A_CTL, 32'h0);
    wr(A_LLO, 32'd2);
    wr(A_LHI, 32'd1);
    wr(A_CTL, 32'h0001_0002);  // E0, count 1:2
    rd(A_VHI, v); check("R3 wide load high", v, 1);
    rd(A_VLO, v); check("R4 wide step", v, 1);
    rd(A_SLO, v); check("R4 wide step", v, 0);
    rd(A_VLO, v); check("R7 low wraps", v, 32'hFFFF_FFFF);
    rd(A_SHI, v); check("R7 borrow into high", v, 0);
    wr(A_CTL, 32'h0001_0000);  // count decrements once more at this edge
    rd(A_VLO, v); check("R13 frozen", v, 32'hFFFF_FFFC);
    idle(3);
    rd(A_SLO, v); check("R13 still frozen", v, 32'hFFFF_FFFC);

    // R3 R7: 32-bit width drops the high load word
    wr(A_INT, 32'h8);
    wr(A_LLO, 32'd1);
    wr(A_LHI, 32'd5);
    wr(A_CTL, 32'h2);          // E0, count 0:1
    rd(A_VHI, v); check("R7 narrow high reads zero", v, 0);
    rd(A_SHI, v); check("R7 narrow shadow high zero", v, 0);
    rd(A_INT, v); check("R4 narrow expiry at E0+2", v, 32'h2);
    rd(A_VLO, v); check("R6 narrow one-shot rests at zero", v, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule